// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 raw interrupt inputs and drives one active-low request line to a processor. Each source has its own mode register and vector register. The mode register sets a 3-bit priority and the trigger type: level or edge, active high or active low. Software enables sources through a write-one-to-set register and disables them through a write-one-to-clear register. It can read back the raw pending set and the enabled set.

Nested preemption is handled in hardware. Reading the vector register acknowledges the winning source and returns that source's vector. The same read pushes the level that was in service onto an internal stack and makes the winner's priority the new in-service level. A write to the end-of-interrupt register restores the previous level. A request is signalled only when an enabled pending source is strictly more urgent than the level in service.

The register port is a plain word-addressed read/write interface with an 8-bit word address and 32-bit data. Read data is combinational and valid in the same cycle as `rdEn`. Any side effect of a read or write takes place at the rising clock edge that ends the access cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irqN` is 1. The enabled set (address 0x03), the pending set (address 0x02) with all inputs low, and the spurious vector (address 0x06) all read 0.
- R2: A write to address 0x00 enables every source whose data bit is 1 and leaves the others unchanged. Address 0x03 reads the enabled set, with bit n standing for source n.
- R3: A write to address 0x01 disables every source whose data bit is 1 and leaves the others unchanged. Writing 0 changes nothing.
- R4: Address 0x02 reads bit n as 1 while source n is active, whether or not it is enabled. Each input passes through two synchroniser flops. A level source (mode bit 3 = 0) is active while its input is high, or while it is low if mode bit 4 = 1.
- R5: An edge source (mode bit 3 = 1) becomes pending on an inactive-to-active transition. It stays pending until it is acknowledged. Holding the input active afterwards does not make it pending again.
- R6: `irqN` is 0 exactly when some enabled pending source has a priority (mode bits 2:0, 7 most urgent) strictly greater than the in-service level. With nothing in service, any enabled pending source qualifies.
- R7: The winner is the enabled pending source with the highest priority. Among equal priorities, the lowest-numbered source wins.
- R8: A read of address 0x04 while `irqN` is 0 returns the winner's vector register. The same read pushes the in-service level, makes the winner's priority the new level, and clears the winner's edge pending flag. Afterwards `irqN` is 1 unless a more urgent source is pending.
- R9: A read of address 0x04 while `irqN` is 1 returns the spurious vector register (address 0x06). It changes no state.
- R10: Any write to address 0x05 restores the most recently stacked level, so sources of that rank are signalled again. With nothing stacked, the write has no effect.
- R11: A more urgent source preempts the one in service. The stack holds 8 entries, which covers a full nesting of all 8 levels without overflow.
- R12: Mode registers at 0x40+n (5 bits) and vector registers at 0x80+n (32 bits) are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Raw interrupt inputs |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of rdEn |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default of 32 sources, which fixes the stack at 8 entries. Sources 16 to 23 are given priorities 0 to 7 and acknowledged one after another. This drives the stack to completely full, then forces a spurious read at the top level. The bench then unwinds the stack one pop at a time and probes the exact restored level with a mid-priority source. An extra end-of-interrupt on the empty stack and ties between equal priorities are also exercised.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 3;
  localparam int MODE_W = 5;
  localparam int ENC_W  = PRIO_W + 1;           // level + 1, 0 = nothing in service
  localparam int STACK_DEPTH = 1 << PRIO_W;

  localparam logic [ADDR_W-1:0] A_ENSET = 8'h00;
  localparam logic [ADDR_W-1:0] A_ENCLR = 8'h01;
  localparam logic [ADDR_W-1:0] A_PEND  = 8'h02;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h03;
  localparam logic [ADDR_W-1:0] A_VECT  = 8'h04;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h05;
  localparam logic [ADDR_W-1:0] A_SPUR  = 8'h06;
  localparam logic [1:0] PAGE_MODE = 2'b01;
  localparam logic [1:0] PAGE_VEC  = 2'b10;

  // mode field positions
  localparam int M_EDGE = 3;
  localparam int M_LOW  = 4;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic modeWr;
    logic vecWr;
    logic spurWr;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  strobe_t             stb,
  output logic                winValid,
  output logic [PRIO_W-1:0]   winPrio,
  output logic [DATA_W-1:0]   rdData
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] sync1, sync2, prevIn, enMask, edgePend;
  logic [NUM_SRC-1:0] pendVec, edgeSeen, isEdge;
  logic [MODE_W-1:0]  modeReg [NUM_SRC];
  logic [DATA_W-1:0]  vecReg  [NUM_SRC];
  logic [DATA_W-1:0]  spurReg;
  logic [PRIO_W-1:0]  prioOf  [NUM_SRC];
  logic [IDX_W-1:0]   winIdx, slot;
  logic               slotOk;

  assign slot   = addr[IDX_W-1:0];
  assign slotOk = int'(addr[5:0]) < NUM_SRC;

  // per-source activity, edge detection and pending view
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic actNow, actPrev;
    assign actNow      = sync2[g]  ^ modeReg[g][M_LOW];
    assign actPrev     = prevIn[g] ^ modeReg[g][M_LOW];
    assign isEdge[g]   = modeReg[g][M_EDGE];
    assign edgeSeen[g] = actNow & ~actPrev;
    assign pendVec[g]  = isEdge[g] ? edgePend[g] : actNow;
    assign prioOf[g]   = modeReg[g][PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1    <= '0;
      sync2    <= '0;
      prevIn   <= '0;
      enMask   <= '0;
      edgePend <= '0;
      spurReg  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        modeReg[i] <= '0;
        vecReg[i]  <= '0;
      end
    end else begin
      sync1  <= srcIn;
      sync2  <= sync1;
      prevIn <= sync2;
      if (stb.enSet) enMask <= enMask | wrData[NUM_SRC-1:0];
      if (stb.enClr) enMask <= enMask & ~wrData[NUM_SRC-1:0];
      if (stb.spurWr) spurReg <= wrData;
      if (stb.modeWr) modeReg[slot] <= wrData[MODE_W-1:0];
      if (stb.vecWr)  vecReg[slot]  <= wrData;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (!isEdge[i])
          edgePend[i] <= 1'b0;
        else if (edgeSeen[i])
          edgePend[i] <= 1'b1;
        else if (stb.ack && winIdx == IDX_W'(i))
          edgePend[i] <= 1'b0;
      end
    end
  end

  // winner: highest priority, lowest index on ties
  always_comb begin
    winValid = 1'b0;
    winPrio  = '0;
    winIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i] && enMask[i] && (!winValid || prioOf[i] >= winPrio)) begin
        winValid = 1'b1;
        winPrio  = prioOf[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == A_PEND)      rdData = DATA_W'(pendVec);
      else if (addr == A_MASK) rdData = DATA_W'(enMask);
      else if (addr == A_VECT) rdData = stb.ack ? vecReg[winIdx] : spurReg;
      else if (addr == A_SPUR) rdData = spurReg;
      else if (addr[7:6] == PAGE_MODE && slotOk) rdData = DATA_W'(modeReg[slot]);
      else if (addr[7:6] == PAGE_VEC && slotOk)  rdData = vecReg[slot];
    end
  end
endmodule

// File: rtl/prio_irq_control.sv
module prio_irq_control
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               winValid,
  input  logic [PRIO_W-1:0]  winPrio,
  output strobe_t            stb,
  output logic               irqN
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  logic [ENC_W-1:0] curEnc, winEnc;
  logic [ENC_W-1:0] stack [STACK_DEPTH];
  logic [SP_W-1:0]  sp, spDec;
  logic             outranks, eoiWr, slotOk;

  assign winEnc   = ENC_W'(winPrio) + ENC_W'(1);
  assign outranks = winValid && (winEnc > curEnc);
  assign irqN     = ~outranks;
  assign eoiWr    = wrEn && addr == A_EOI;
  assign spDec    = sp - SP_W'(1);
  assign slotOk   = int'(addr[5:0]) < NUM_SRC;

  always_comb begin
    stb        = '0;
    stb.enSet  = wrEn && addr == A_ENSET;
    stb.enClr  = wrEn && addr == A_ENCLR;
    stb.spurWr = wrEn && addr == A_SPUR;
    stb.modeWr = wrEn && addr[7:6] == PAGE_MODE && slotOk;
    stb.vecWr  = wrEn && addr[7:6] == PAGE_VEC && slotOk;
    stb.ack    = rdEn && addr == A_VECT && outranks;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curEnc <= '0;
      sp     <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stack[i] <= '0;
    end else if (stb.ack) begin
      stack[sp[PRIO_W-1:0]] <= curEnc;
      sp     <= sp + SP_W'(1);
      curEnc <= winEnc;
    end else if (eoiWr && sp != '0) begin
      sp     <= spDec;
      curEnc <= stack[spDec[PRIO_W-1:0]];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [7:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqN
);
  strobe_t           stb;
  logic              winValid;
  logic [PRIO_W-1:0] winPrio;

  prio_irq_control #(.NUM_SRC(NUM_SRC)) u_ctl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .winValid(winValid), .winPrio(winPrio), .stb(stb), .irqN(irqN)
  );

  prio_irq_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .stb(stb), .winValid(winValid), .winPrio(winPrio),
    .rdData(rdData)
  );
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic [7:0]        addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              irqN,
  input strobe_t           stb,
  input logic              winValid,
  input logic [PRIO_W-1:0] winPrio
);
  logic [3:0]  depthCnt;
  logic [31:0] spurShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthCnt   <= '0;
      spurShadow <= '0;
    end else begin
      if (wrEn && addr == A_SPUR) spurShadow <= wrData;
      if (stb.ack) depthCnt <= depthCnt + 4'd1;
      else if (wrEn && addr == A_EOI && depthCnt != 4'd0) depthCnt <= depthCnt - 4'd1;
    end
  end

  // R6: a request always has an enabled pending source behind it
  a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> winValid);

  // R6: idle controller signals any enabled pending source
  a_r6_idle_any_src: assert property (@(posedge clk) disable iff (!rstN)
    (depthCnt == 4'd0 && winValid) |-> !irqN);

  // R8: after acknowledge, request stays low only for a more urgent source
  a_r8_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> (irqN || winPrio > $past(winPrio)));

  // R9: vector read with no request returns the spurious vector
  a_r9_spurious_value: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_VECT && irqN) |-> rdData == spurShadow);

  // R11: an acknowledge never finds the level stack full
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |-> depthCnt < 4'(STACK_DEPTH));
endmodule

bind prio_irq_ctrl prio_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .irqN(irqN), .stb(stb),
  .winValid(winValid), .winPrio(winPrio)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int NS = 32;
  localparam int TW = 82;   // op(2) addr(8) data(32) exp(32) req(8)
  localparam int NT = 17;

  // op 0 = write, 1 = read and compare
  localparam logic [TW-1:0] TBL [NT] = '{
    {2'd1, 8'h03, 32'h0,          32'h0,          8'd1},  // R1 enabled set empty
    {2'd1, 8'h02, 32'h0,          32'h0,          8'd1},  // R1 nothing pending
    {2'd1, 8'h04, 32'h0,          32'h0,          8'd1},  // R1 spurious resets to 0
    {2'd0, 8'h00, 32'h0000_00F0,  32'h0,          8'd2},
    {2'd1, 8'h03, 32'h0,          32'h0000_00F0,  8'd2},  // R2
    {2'd0, 8'h00, 32'h0000_0003,  32'h0,          8'd2},
    {2'd1, 8'h03, 32'h0,          32'h0000_00F3,  8'd2},  // R2 zeros keep others
    {2'd0, 8'h01, 32'h0000_0030,  32'h0,          8'd3},
    {2'd1, 8'h03, 32'h0,          32'h0000_00C3,  8'd3},  // R3
    {2'd0, 8'h01, 32'h0,          32'h0,          8'd3},
    {2'd1, 8'h03, 32'h0,          32'h0000_00C3,  8'd3},  // R3 zero write no effect
    {2'd0, 8'h45, 32'hFFFF_FFFD,  32'h0,          8'd12},
    {2'd1, 8'h45, 32'h0,          32'h0000_001D,  8'd12}, // R12 5-bit mode
    {2'd0, 8'h9F, 32'hDEAD_BEEF,  32'h0,          8'd12},
    {2'd1, 8'h9F, 32'h0,          32'hDEAD_BEEF,  8'd12}, // R12 vector
    {2'd0, 8'h06, 32'h0000_0BAD,  32'h0,          8'd9},
    {2'd1, 8'h04, 32'h0,          32'h0000_0BAD,  8'd9}   // R9 spurious
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcIn = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqN;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS)) u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 check(req, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic irqChk(input logic exp, input int req);
    @(negedge clk);
    #1 check(req, {31'b0, irqN}, {31'b0, exp});
  endtask

  task automatic waitSync();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    irqChk(1'b1, 1);                      // R1 request idle after reset

    for (int t = 0; t < NT; t++) begin
      logic [TW-1:0] e;
      e = TBL[t];
      if (e[81:80] == 2'd0) wr(e[79:72], e[71:40]);
      else rdChk(e[79:72], e[39:8], int'(e[7:0]));
    end
    wr(8'h45, 32'h0);
    wr(8'h01, 32'hFFFF_FFFF);

    // R4 level sources, both polarities, pending regardless of enable
    wr(8'h42, 32'h01);
    wr(8'h82, 32'h22);
    wr(8'h49, 32'h10);
    srcIn[2] = 1'b1;
    waitSync();
    rdChk(8'h02, 32'h0000_0204, 4);
    irqChk(1'b1, 6);                      // R6 not enabled, no request
    wr(8'h00, 32'h4);
    irqChk(1'b0, 6);                      // R6 enabled source, nothing in service
    rdChk(8'h04, 32'h22, 8);              // R8 winner's vector
    irqChk(1'b1, 8);                      // R8 request released
    rdChk(8'h02, 32'h0000_0204, 4);       // R4 level stays pending
    wr(8'h05, 32'h0);
    irqChk(1'b0, 10);                     // R10 same rank signalled again
    rdChk(8'h04, 32'h22, 8);
    wr(8'h05, 32'h0);
    srcIn[2] = 1'b0;
    wr(8'h49, 32'h0);
    waitSync();
    rdChk(8'h02, 32'h0, 4);
    wr(8'h01, 32'hFFFF_FFFF);

    // R7 ties and priority order
    wr(8'h43, 32'h4);
    wr(8'h44, 32'h4);
    wr(8'h83, 32'h33);
    wr(8'h84, 32'h44);
    wr(8'h00, 32'h18);
    srcIn[3] = 1'b1; srcIn[4] = 1'b1;
    waitSync();
    irqChk(1'b0, 6);
    rdChk(8'h04, 32'h33, 7);              // R7 lowest index wins tie
    irqChk(1'b1, 6);                      // R6 equal priority does not preempt
    wr(8'h05, 32'h0);
    irqChk(1'b0, 10);
    srcIn[3] = 1'b0;
    waitSync();
    rdChk(8'h04, 32'h44, 7);
    wr(8'h4A, 32'h6);
    wr(8'h8A, 32'hAA);
    wr(8'h00, 32'h400);
    srcIn[10] = 1'b1;
    waitSync();
    irqChk(1'b0, 11);                     // R11 more urgent preempts
    rdChk(8'h04, 32'hAA, 7);              // R7 higher priority beats lower index
    wr(8'h05, 32'h0);
    wr(8'h05, 32'h0);
    srcIn = '0;
    wr(8'h01, 32'hFFFF_FFFF);

    // R5 edge source
    wr(8'h4C, 32'h0B);
    wr(8'h8C, 32'hC0);
    wr(8'h00, 32'h1000);
    srcIn[12] = 1'b1;
    waitSync();
    rdChk(8'h02, 32'h0000_1000, 5);
    rdChk(8'h04, 32'hC0, 8);
    rdChk(8'h02, 32'h0, 5);               // R5 cleared by acknowledge while held
    wr(8'h05, 32'h0);
    irqChk(1'b1, 5);                      // R5 held input does not re-pend
    srcIn[12] = 1'b0;
    waitSync();
    srcIn[12] = 1'b1;
    waitSync();
    irqChk(1'b0, 5);                      // R5 new edge pends again
    rdChk(8'h04, 32'hC0, 5);
    wr(8'h05, 32'h0);
    srcIn = '0;
    wr(8'h4C, 32'h0);
    wr(8'h01, 32'hFFFF_FFFF);

    // R11 full nesting through all 8 levels
    for (int k = 0; k < 8; k++) begin
      wr(8'(8'h50 + k), 32'(k));
      wr(8'(8'h90 + k), 32'(32'h100 + k));
    end
    wr(8'h00, 32'h00FF_0000);
    for (int k = 0; k < 8; k++) begin
      srcIn[16 + k] = 1'b1;
      waitSync();
      irqChk(1'b0, 11);
      rdChk(8'h04, 32'(32'h100 + k), 11);
    end
    rdChk(8'h04, 32'h0000_0BAD, 9);       // R9 nothing outranks level 7
    srcIn = '0;
    srcIn[20] = 1'b1;
    waitSync();
    irqChk(1'b1, 10);
    wr(8'h05, 32'h0);                     // back to level 6
    irqChk(1'b1, 10);
    wr(8'h05, 32'h0);                     // 5
    irqChk(1'b1, 10);
    wr(8'h05, 32'h0);                     // 4
    irqChk(1'b1, 10);
    wr(8'h05, 32'h0);                     // 3
    irqChk(1'b0, 10);                     // R10 exact level restored
    rdChk(8'h04, 32'h104, 8);
    wr(8'h05, 32'h0);
    irqChk(1'b0, 10);
    srcIn[20] = 1'b0;
    waitSync();
    irqChk(1'b1, 10);
    for (int k = 0; k < 4; k++) wr(8'h05, 32'h0);
    wr(8'h05, 32'h0);                     // R10 empty stack, no effect
    srcIn[16] = 1'b1;
    waitSync();
    irqChk(1'b0, 10);                     // nothing in service: priority 0 requests
    rdChk(8'h04, 32'h100, 8);
    wr(8'h05, 32'h0);
    srcIn = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule